// File: doc/BRIEF.md
# Eight-Channel DAC Command Decoder

This block is the digital control core behind a multi-channel voltage DAC. A two-wire bus slave front end hands it whole bytes, together with strobes that mark the start and the stop of each write frame and the phases of a read. The core gathers the bytes into 24-bit command words. It decodes a 4-bit operation and a 4-bit channel address from the first byte and runs the operation on a two-stage register set: an input stage and an output (DAC) stage for each channel. It also holds a transparent-load mask, a clear-code selector, per-channel power-down flags and an internal-reference enable.

A write is three bytes: command, data high, data low. The data word is 16 bits, and the channel code sits left-justified in it: with the default 12-bit code the low four bits are ignored. After the block has been put into multi-byte mode, bit 6 of each command byte becomes a repeat flag. A command sent with that flag lets any number of further high/low data pairs follow in the same frame, and each pair reuses the stored operation and address. A read returns the input register of the last addressed channel as a high byte followed by a low byte.

Top module: `dac_cmd_core`

## Requirements
- R1: While `rst` is high and on the cycle after, every DAC code, `ld_mask`, `pd_ch`, `clr_code`, `ref_en`, `mb_en`, `rd_dat` and `rd_act` read zero, and all input registers hold zero.
- R2: After `frm_start`, byte 1 is the command (bits 7:4 operation, bits 3:0 address), byte 2 is data bits 15:8 and byte 3 is data bits 7:0. The word executes one cycle after the third byte is taken, and its outputs appear on the cycle after that. Without the repeat flag, further bytes are ignored until the next `frm_start`. Operation 0 writes the input register(s) only, and the DAC outputs stay unchanged unless R5 applies.
- R3: Address 0 to 7 selects one channel and address 15 selects all channels. Addresses 8 to 14 select no channel. Operation 1 copies input to DAC for the selection, and operation 3 writes input and DAC of the selection with the code data[15:4].
- R4: Operation 2 writes the selected input register(s) and then loads every channel's DAC register from its input register. All outputs change on the same clock edge.
- R5: Operation 6 loads `ld_mask` from data[7:0]. A channel whose mask bit is 1 also updates its DAC register when operation 0 writes its input register.
- R6: Operation 4 updates `pd_ch[i]` for each channel i whose bit in data[7:0] is 1. The new value is 1 (powered down) if data[9:8] is nonzero and 0 otherwise. Operation 5 loads `clr_code` from data[1:0], and operation 8 loads `ref_en` from data[0].
- R7: Operations 10 to 15 change no output and no input register.
- R8: Operation 7 returns every register to its R1 value.
- R9: Operation 9 sets `mb_en`. While `mb_en` is 1, command byte bit 6 is the repeat flag and the operation is {bit7, 0, bit5, bit4}. With the flag set, each later high/low pair in the same frame executes again with the stored operation and address. With the flag clear, the block goes back to three-byte framing.
- R10: A `frm_stop` or `frm_start` in the middle of a word discards the partial word, and `mb_en` stays set.
- R11: `rd_start` snapshots the input register of the last addressed channel (channel 0 if the address is 8 or above) and presents data[15:8] of that value on `rd_dat`, with `rd_act` set. Each `rd_ack` alternates to the low byte and back to the high byte. `rd_nack` clears `rd_act` and `rd_dat`. A snapshot taken in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start of a write frame (after the bus address byte) |
| frm_stop | input | 1 | Stop condition |
| byte_vld | input | 1 | One received byte is valid this cycle |
| byte_dat | input | 8 | Received byte |
| rd_start | input | 1 | Start of a read frame |
| rd_ack | input | 1 | Master acknowledged the read byte and wants the next |
| rd_nack | input | 1 | Master did not acknowledge; read ends |
| dac_code | output | NCH*CW | DAC register codes, channel i at bits i*CW upward |
| ld_mask | output | NCH | Transparent-load mask |
| pd_ch | output | NCH | Per-channel power-down flags |
| clr_code | output | 2 | Clear-code selector |
| ref_en | output | 1 | Internal reference enable |
| mb_en | output | 1 | Multi-byte mode active |
| rd_dat | output | 8 | Read byte |
| rd_act | output | 1 | Read in progress |

## Verification
Two functions can fall in one cycle: a word executing into the input registers and a read snapshot of the same channel. The bench raises `rd_start` exactly in the cycle when the written word is being applied. It then expects the old high byte, and after the acknowledge the old low byte, while the DAC outputs already show the new code. A second pair is the software load, where one command writes one channel and loads all eight. The bench samples the outputs one cycle before and one cycle after that edge and requires that all channels show either the old values or the new ones, never a mix.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam logic [3:0] OP_WR_IN    = 4'h0;
  localparam logic [3:0] OP_UPD      = 4'h1;
  localparam logic [3:0] OP_WR_LDALL = 4'h2;
  localparam logic [3:0] OP_WR_UPD   = 4'h3;
  localparam logic [3:0] OP_PWR      = 4'h4;
  localparam logic [3:0] OP_CLR      = 4'h5;
  localparam logic [3:0] OP_MASK     = 4'h6;
  localparam logic [3:0] OP_RST      = 4'h7;
  localparam logic [3:0] OP_REF      = 4'h8;
  localparam logic [3:0] OP_MB       = 4'h9;
  localparam logic [3:0] ADDR_ALL    = 4'hF;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  addr;
    logic [15:0] data;
  } word_t;

  typedef enum logic [1:0] {F_CMD, F_MSB, F_LSB, F_SKIP} fst_e;
endpackage

// File: rtl/dcd_frame.sv
module dcd_frame
  import dcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frm_start,
  input  logic       frm_stop,
  input  logic       byte_vld,
  input  logic [7:0] byte_dat,
  input  logic       mb_en,
  output logic       word_vld,
  output word_t      word
);
  fst_e       st;
  logic [7:0] msb_q;
  logic       rep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= F_CMD;
      msb_q     <= '0;
      rep_q     <= 1'b0;
      word_vld  <= 1'b0;
      word      <= '0;
    end else begin
      word_vld <= 1'b0;
      if (frm_start || frm_stop) begin
        st <= F_CMD;
      end else if (byte_vld) begin
        case (st)
          F_CMD: begin
            word.op   <= mb_en ? {byte_dat[7], 1'b0, byte_dat[5:4]} : byte_dat[7:4];
            word.addr <= byte_dat[3:0];
            rep_q     <= mb_en & byte_dat[6];
            st        <= F_MSB;
          end
          F_MSB: begin
            msb_q <= byte_dat;
            st    <= F_LSB;
          end
          F_LSB: begin
            word.data <= {msb_q, byte_dat};
            word_vld  <= 1'b1;
            st        <= rep_q ? F_MSB : F_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcd_exec.sv
module dcd_exec
  import dcd_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  word_t             word,
  output logic [NCH*CW-1:0] in_flat,
  output logic [NCH*CW-1:0] dac_flat,
  output logic [NCH-1:0]    ld_mask,
  output logic [NCH-1:0]    pd_ch,
  output logic [1:0]        clr_code,
  output logic              ref_en,
  output logic              mb_en
);
  logic          full_rst;
  logic [CW-1:0] code;
  logic          op_in_wr;
  logic          op_dac_sel;

  assign full_rst   = rst || (word_vld && word.op == OP_RST);
  assign code       = word.data[15 -: CW];
  assign op_in_wr   = (word.op == OP_WR_IN) || (word.op == OP_WR_LDALL) || (word.op == OP_WR_UPD);
  assign op_dac_sel = (word.op == OP_UPD) || (word.op == OP_WR_UPD);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] in_q, dac_q, in_nx;
    logic          sel, in_wr, dac_ld;

    assign sel    = (word.addr == ADDR_ALL) || (word.addr == 4'(i));
    assign in_wr  = word_vld && sel && op_in_wr;
    assign in_nx  = in_wr ? code : in_q;
    assign dac_ld = word_vld && ((sel && op_dac_sel) ||
                                 (word.op == OP_WR_LDALL) ||
                                 (sel && word.op == OP_WR_IN && ld_mask[i]));

    always_ff @(posedge clk) begin
      if (full_rst) begin
        in_q  <= '0;
        dac_q <= '0;
      end else begin
        in_q <= in_nx;
        if (dac_ld) dac_q <= in_nx;
      end
    end

    assign in_flat[i*CW +: CW]  = in_q;
    assign dac_flat[i*CW +: CW] = dac_q;
  end

  always_ff @(posedge clk) begin
    if (full_rst) begin
      ld_mask  <= '0;
      pd_ch    <= '0;
      clr_code <= '0;
      ref_en   <= 1'b0;
      mb_en    <= 1'b0;
    end else if (word_vld) begin
      case (word.op)
        OP_PWR: begin
          for (int i = 0; i < NCH; i++)
            if (word.data[i]) pd_ch[i] <= |word.data[9:8];
        end
        OP_CLR:  clr_code <= word.data[1:0];
        OP_MASK: ld_mask  <= word.data[NCH-1:0];
        OP_REF:  ref_en   <= word.data[0];
        OP_MB:   mb_en    <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dcd_readback.sv
module dcd_readback #(
  parameter int NCH = 8,
  parameter int CW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic              rd_ack,
  input  logic              rd_nack,
  input  logic [3:0]        addr,
  input  logic [NCH*CW-1:0] in_flat,
  output logic [7:0]        rd_dat,
  output logic              rd_act
);
  logic [3:0]  ch;
  logic [15:0] cur16;
  logic [15:0] snap_q;
  logic        lo_next;

  assign ch    = (addr < 4'(NCH)) ? addr : 4'd0;
  assign cur16 = 16'(in_flat[ch*CW +: CW]) << (16 - CW);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rd_dat  <= '0;
      rd_act  <= 1'b0;
      lo_next <= 1'b0;
    end else if (rd_nack) begin
      rd_dat  <= '0;
      rd_act  <= 1'b0;
      lo_next <= 1'b0;
    end else if (rd_start) begin
      snap_q  <= cur16;
      rd_dat  <= cur16[15:8];
      rd_act  <= 1'b1;
      lo_next <= 1'b1;
    end else if (rd_ack && rd_act) begin
      rd_dat  <= lo_next ? snap_q[7:0] : snap_q[15:8];
      lo_next <= !lo_next;
    end
  end
endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core
  import dcd_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              frm_stop,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic              rd_start,
  input  logic              rd_ack,
  input  logic              rd_nack,
  output logic [NCH*CW-1:0] dac_code,
  output logic [NCH-1:0]    ld_mask,
  output logic [NCH-1:0]    pd_ch,
  output logic [1:0]        clr_code,
  output logic              ref_en,
  output logic              mb_en,
  output logic [7:0]        rd_dat,
  output logic              rd_act
);
  logic              word_vld;
  word_t             word;
  logic [NCH*CW-1:0] in_flat;

  dcd_frame u_frame (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_stop(frm_stop),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .mb_en(mb_en),
    .word_vld(word_vld), .word(word)
  );

  dcd_exec #(.NCH(NCH), .CW(CW)) u_exec (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
    .in_flat(in_flat), .dac_flat(dac_code), .ld_mask(ld_mask), .pd_ch(pd_ch),
    .clr_code(clr_code), .ref_en(ref_en), .mb_en(mb_en)
  );

  dcd_readback #(.NCH(NCH), .CW(CW)) u_rd (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_ack(rd_ack), .rd_nack(rd_nack),
    .addr(word.addr), .in_flat(in_flat), .rd_dat(rd_dat), .rd_act(rd_act)
  );
endmodule

// File: rtl/dac_cmd_core_chk.sv
module dac_cmd_core_chk #(
  parameter int NCH = 8,
  parameter int CW  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wvld,
  input logic [23:0]       wrd,
  input logic [NCH*CW-1:0] dac_code,
  input logic [NCH-1:0]    ld_mask,
  input logic [NCH-1:0]    pd_ch,
  input logic [1:0]        clr_code,
  input logic              ref_en,
  input logic              mb_en,
  input logic              rd_nack,
  input logic              rd_act,
  input logic [7:0]        rd_dat
);
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      // R1
      reset_state_chk: assert (dac_code == '0 && ld_mask == '0 && pd_ch == '0 &&
                               clr_code == '0 && !ref_en && !mb_en && !rd_act && rd_dat == '0);
    end
  end

  // R7
  reserved_noeffect_chk: assert property (@(posedge clk) disable iff (rst)
    (wvld && wrd[23:20] >= 4'hA) |=> ($stable(dac_code) && $stable(ld_mask) && $stable(pd_ch) &&
                                      $stable(clr_code) && $stable(ref_en) && $stable(mb_en)));

  // R2
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wvld |=> $stable(dac_code));

  // R10
  mb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mb_en) |-> $past(wvld && wrd[23:20] == 4'h7));

  // R6
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_en) |-> $past(wvld && (wrd[23:20] == 4'h8 || wrd[23:20] == 4'h7)));

  // R11
  rd_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_act) |-> $past(rd_nack));
endmodule

bind dac_cmd_core dac_cmd_core_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wvld(word_vld), .wrd(word), .dac_code(dac_code),
  .ld_mask(ld_mask), .pd_ch(pd_ch), .clr_code(clr_code), .ref_en(ref_en),
  .mb_en(mb_en), .rd_nack(rd_nack), .rd_act(rd_act), .rd_dat(rd_dat)
);

// File: tb/sim_dac_cmd_core.sv
module sim_dac_cmd_core;
  localparam int NCH = 8;
  localparam int CW  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 0, frm_stop = 0, byte_vld = 0, rd_start = 0, rd_ack = 0, rd_nack = 0;
  logic [7:0] byte_dat = '0;
  logic [NCH*CW-1:0] dac_code;
  logic [NCH-1:0] ld_mask, pd_ch;
  logic [1:0] clr_code;
  logic ref_en, mb_en, rd_act;
  logic [7:0] rd_dat;

  always #2 clk = ~clk;

  dac_cmd_core #(.NCH(NCH), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_stop(frm_stop),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .rd_start(rd_start), .rd_ack(rd_ack),
    .rd_nack(rd_nack), .dac_code(dac_code), .ld_mask(ld_mask), .pd_ch(pd_ch),
    .clr_code(clr_code), .ref_en(ref_en), .mb_en(mb_en), .rd_dat(rd_dat), .rd_act(rd_act)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [CW-1:0] m_in [NCH];
  logic [CW-1:0] m_dac [NCH];
  logic [NCH-1:0] m_mask, m_pd;
  logic [1:0] m_clr;
  logic m_ref, m_mb, m_rep;
  logic [3:0] m_op, m_addr;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    m_mask = '0; m_pd = '0; m_clr = '0; m_ref = 0; m_mb = 0; m_rep = 0;
  endtask

  function automatic logic [NCH*CW-1:0] exp_dac();
    logic [NCH*CW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*CW +: CW] = m_dac[i];
    return v;
  endfunction

  task automatic model_word(logic [15:0] d);
    logic [CW-1:0] c;
    c = d[15 -: CW];
    for (int i = 0; i < NCH; i++) begin
      bit s;
      s = (m_addr == 4'hF) || (m_addr == 4'(i));
      case (m_op)
        4'h0: if (s) begin m_in[i] = c; if (m_mask[i]) m_dac[i] = c; end
        4'h1: if (s) m_dac[i] = m_in[i];
        4'h2: begin if (s) m_in[i] = c; m_dac[i] = m_in[i]; end
        4'h3: if (s) begin m_in[i] = c; m_dac[i] = c; end
        4'h4: if (d[i]) m_pd[i] = |d[9:8];
        default: ;
      endcase
    end
    case (m_op)
      4'h5: m_clr = d[1:0];
      4'h6: m_mask = d[NCH-1:0];
      4'h7: model_reset();
      4'h8: m_ref = d[0];
      4'h9: m_mb = 1;
      default: ;
    endcase
  endtask

  task automatic cmp_all(string req);
    chk(req, 128'(dac_code), 128'(exp_dac()));
    chk(req, 128'({ld_mask, pd_ch, clr_code, ref_en, mb_en}),
             128'({m_mask, m_pd, m_clr, m_ref, m_mb}));
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); byte_vld = 1; byte_dat = b;
    @(negedge clk); byte_vld = 0;
  endtask

  task automatic pstart(); @(negedge clk); frm_start = 1; @(negedge clk); frm_start = 0; endtask
  task automatic pstop();  @(negedge clk); frm_stop = 1;  @(negedge clk); frm_stop = 0;  endtask

  task automatic cmd_byte(logic [7:0] b);
    send_byte(b);
    m_op   = m_mb ? {b[7], 1'b0, b[5:4]} : b[7:4];
    m_addr = b[3:0];
    m_rep  = m_mb & b[6];
  endtask

  task automatic pair(logic [15:0] d);
    send_byte(d[15:8]); send_byte(d[7:0]);
    @(negedge clk);
    model_word(d);
  endtask

  task automatic write3(logic [7:0] cb, logic [15:0] d);
    pstart(); cmd_byte(cb); pair(d); pstop();
  endtask

  task automatic rd_check(string req);
    logic [15:0] v;
    v = 16'(m_in[(m_addr < 4'(NCH)) ? m_addr : 4'd0]) << (16 - CW);
    @(negedge clk); rd_start = 1; @(negedge clk); rd_start = 0;
    chk(req, 128'({rd_act, rd_dat}), 128'({1'b1, v[15:8]}));
    @(negedge clk); rd_ack = 1; @(negedge clk); rd_ack = 0;
    chk(req, 128'(rd_dat), 128'(v[7:0]));
    @(negedge clk); rd_ack = 1; @(negedge clk); rd_ack = 0;
    chk(req, 128'(rd_dat), 128'(v[15:8]));
    @(negedge clk); rd_nack = 1; @(negedge clk); rd_nack = 0;
    chk(req, 128'({rd_act, rd_dat}), 128'(0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [NCH*CW-1:0] old_d;
    logic [15:0] v;
    void'($urandom(32'd1234));
    model_reset();
    m_op = 0; m_addr = 0;
    repeat (5) @(negedge clk);
    chk("R1", 128'({rd_act, rd_dat, dac_code}), 128'(0));
    rst = 0;
    @(negedge clk);
    cmp_all("R1");
    chk("R1", 128'({rd_act, rd_dat}), 128'(0));

    // R2 write input only, extra bytes skipped
    pstart(); cmd_byte(8'h02); pair(16'hABC0); send_byte(8'hFF); send_byte(8'hFF); pstop();
    cmp_all("R2");
    rd_check("R2");
    // R3 copy, write+update, all, invalid address
    write3(8'h12, 16'h0000); cmp_all("R3");
    write3(8'h35, 16'h5550); cmp_all("R3");
    write3(8'h3F, 16'h1230); cmp_all("R3");
    write3(8'h39, 16'hEEE0); cmp_all("R3");
    write3(8'h04, 16'h7770); write3(8'h06, 16'h9990);
    // R4 software load, all channels same edge
    old_d = exp_dac();
    pstart(); cmd_byte(8'h21); send_byte(8'h44); send_byte(8'h40);
    chk("R4", 128'(dac_code), 128'(old_d));
    @(negedge clk); model_word(16'h4440);
    chk("R4", 128'(dac_code), 128'(exp_dac()));
    pstop();
    // R5 load mask transparency
    write3(8'h60, 16'h0005); cmp_all("R5");
    write3(8'h00, 16'h1110); write3(8'h01, 16'h2220); cmp_all("R5");
    // R6 power, clear, reference
    write3(8'h40, 16'h01A5); cmp_all("R6");
    write3(8'h40, 16'h0021); cmp_all("R6");
    write3(8'h50, 16'h0003); write3(8'h80, 16'h0001); cmp_all("R6");
    // R7 reserved
    for (int k = 10; k < 16; k++) begin
      write3({4'(k), 4'hF}, 16'hFFFF); cmp_all("R7");
    end
    rd_check("R7");
    // R8 reset command
    write3(8'h7F, 16'h0000); cmp_all("R8"); rd_check("R8");
    // R9 multi-byte mode
    write3(8'h90, 16'h0000); cmp_all("R9");
    pstart(); cmd_byte(8'h73); pair(16'h1010); cmp_all("R9");
    pair(16'h2020); cmp_all("R9"); pair(16'h3030); pstop(); cmp_all("R9");
    pstart(); cmd_byte(8'h32); pair(16'h4040); send_byte(8'h55); send_byte(8'h55); pstop();
    cmp_all("R9");
    // R10 partial word discarded, mode kept
    pstart(); cmd_byte(8'h31); send_byte(8'hFF); pstop(); @(negedge clk); cmp_all("R10");
    pstart(); cmd_byte(8'h31); send_byte(8'hFF); pstart(); cmd_byte(8'h31); pair(16'h6060); pstop();
    cmp_all("R10");
    // R11 snapshot in the same cycle as the write
    v = 16'(m_in[2]) << (16 - CW);
    pstart(); cmd_byte(8'h32); send_byte(8'hCD); send_byte(8'hE0);
    rd_start = 1; @(negedge clk); rd_start = 0; model_word(16'hCDE0);
    chk("R11", 128'({rd_act, rd_dat}), 128'({1'b1, v[15:8]}));
    chk("R11", 128'(dac_code), 128'(exp_dac()));
    @(negedge clk); rd_ack = 1; @(negedge clk); rd_ack = 0;
    chk("R11", 128'(rd_dat), 128'(v[7:0]));
    @(negedge clk); rd_nack = 1; @(negedge clk); rd_nack = 0; pstop();
    rd_check("R11");

    // random traffic
    write3(8'h7F, 16'h0000);
    for (int n = 0; n < 300; n++) begin
      logic [3:0] op, ad;
      int r;
      r = $urandom_range(0, 19);
      op = (r < 12) ? 4'(r % 4) : 4'($urandom_range(4, 15));
      if (op == 4'h7 && $urandom_range(0, 3) != 0) op = 4'h3;
      r = $urandom_range(0, 9);
      ad = (r < 8) ? 4'(r) : (r == 8 ? 4'hF : 4'h9);
      pstart();
      cmd_byte({op[3], 1'($urandom_range(0, 1)), op[1:0], ad});
      pair(16'($urandom));
      if (m_rep) for (int p = 0; p < $urandom_range(0, 3); p++) pair(16'($urandom));
      pstop();
      cmp_all("R2 R3 R4 R5 R6 R7 R9 random");
      if (n % 25 == 0) rd_check("R11 random");
    end
    finish_run();
  end
endmodule